// File: doc/BRIEF.md
# Endpoint DMA Request Flags

This block holds one request flag per logical endpoint of a device-side serial bus controller. A set flag tells a DMA engine that the endpoint has data to move. Flags are raised from two sources. An ordinary endpoint (bulk or interrupt type) raises its flag when its own endpoint event arrives while its processor interrupt is masked off. An isochronous endpoint ignores its own event and raises its flag on the shared frame event, again only while its interrupt is masked off. The DMA engine lowers a flag by reporting that the transfer for that endpoint has finished.

The flag word is presented to software as a read-only status value, with bit n for endpoint n. For each endpoint the block also produces a one-cycle start strobe when the flag and that endpoint's DMA enable become true together. The lowest endpoints are control endpoints. Their flags never rise, and their DMA enables are ignored.

Top module: `ep_dma_req`

## Requirements
- R1: While `rst` is high, and after it falls before any stimulus, `req_status` and `start_pulse` are all zero.
- R2: A non-isochronous endpoint n (`ep_iso[n]`=0) whose `ep_evt[n]` is 1 while `ep_irq_en[n]` is 0 has `req_status[n]`=1 after the next clock edge.
- R3: An endpoint event on an endpoint whose `ep_irq_en` bit is 1 leaves its flag unchanged.
- R4: An isochronous endpoint (`ep_iso[n]`=1) with `ep_irq_en[n]`=0 sets its flag when `frame_evt` is 1, and its own `ep_evt[n]` does not set it.
- R5: `frame_evt` does not set the flag of a non-isochronous endpoint.
- R6: Endpoints below `NUM_CTRL` (0 and 1 by default) never set a flag and never strobe, whatever their inputs and `dma_en` bits.
- R7: `xfer_done[n]`=1 clears `req_status[n]` at the next clock edge.
- R8: When a set condition and `xfer_done[n]` occur in the same cycle, the flag ends up set.
- R9: `start_pulse[n]` is high for exactly one cycle, one clock after `req_status[n] & dma_en[n]` rises. It rises again only after that product has been low.
- R10: A flag that is set while `dma_en[n]`=0 produces no strobe. Enabling DMA later produces the strobe.
- R11: A set flag holds its value until `xfer_done[n]` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_evt | input | NUM_EP | Per-endpoint event pulses |
| frame_evt | input | 1 | Frame event pulse |
| ep_irq_en | input | NUM_EP | Per-endpoint interrupt enable (1 blocks requests) |
| ep_iso | input | NUM_EP | Per-endpoint isochronous-type mask |
| dma_en | input | NUM_EP | Per-endpoint DMA enable |
| xfer_done | input | NUM_EP | Per-endpoint transfer-complete pulses from the DMA engine |
| req_status | output | NUM_EP | Registered request flags, bit n = endpoint n |
| start_pulse | output | NUM_EP | Registered one-cycle start strobes |

## Verification
The bench builds the block with its defaults: 32 endpoints, two of them control endpoints. At this size it reaches both ends of the flag word. It drives the control pair at bit 0 and 1, ordinary endpoints in the middle, and an isochronous endpoint at bit 31. With 32 endpoints, one stimulus word can mix masked, unmasked, isochronous and control endpoints, so a single step shows that each endpoint's rule does not leak into its neighbours.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;

  typedef enum logic [1:0] {
    TRIG_NONE  = 2'd0,
    TRIG_EVENT = 2'd1,
    TRIG_FRAME = 2'd2
  } trig_e;

  // Which event source may raise a flag for one endpoint.
  function automatic trig_e pick_trig(input logic is_iso, input logic irq_en);
    if (irq_en)      return TRIG_NONE;
    else if (is_iso) return TRIG_FRAME;
    else             return TRIG_EVENT;
  endfunction

endpackage

// File: rtl/ep_req_cell.sv
module ep_req_cell
  import ep_dma_pkg::*;
#(
  parameter bit IS_CTRL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic ep_evt,
  input  logic frame_evt,
  input  logic irq_en,
  input  logic is_iso,
  input  logic done,
  output logic flag
);

  trig_e trig;
  logic  set_raw;
  logic  set_ok;

  always_comb begin
    trig = pick_trig(is_iso, irq_en);
    unique case (trig)
      TRIG_EVENT: set_raw = ep_evt;
      TRIG_FRAME: set_raw = frame_evt;
      default:    set_raw = 1'b0;
    endcase
    set_ok = set_raw & ~IS_CTRL;
  end

  // set has priority over clear
  always_ff @(posedge clk) begin
    if (rst)         flag <= 1'b0;
    else if (set_ok) flag <= 1'b1;
    else if (done)   flag <= 1'b0;
  end

endmodule

// File: rtl/ep_start_gen.sv
module ep_start_gen #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flag,
  input  logic [N-1:0] dma_ok,
  output logic [N-1:0] pulse
);

  logic [N-1:0] armed;
  logic [N-1:0] armed_q;

  assign armed = flag & dma_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= '0;
      pulse   <= '0;
    end else begin
      armed_q <= armed;
      pulse   <= armed & ~armed_q;
    end
  end

endmodule

// File: rtl/ep_dma_req.sv
module ep_dma_req #(
  parameter int unsigned NUM_EP   = 32,
  parameter int unsigned NUM_CTRL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] ep_evt,
  input  logic              frame_evt,
  input  logic [NUM_EP-1:0] ep_irq_en,
  input  logic [NUM_EP-1:0] ep_iso,
  input  logic [NUM_EP-1:0] dma_en,
  input  logic [NUM_EP-1:0] xfer_done,
  output logic [NUM_EP-1:0] req_status,
  output logic [NUM_EP-1:0] start_pulse
);

  localparam logic [NUM_EP-1:0] CTRL_MASK = {{(NUM_EP-NUM_CTRL){1'b0}}, {NUM_CTRL{1'b1}}};

  logic [NUM_EP-1:0] flags;
  logic [NUM_EP-1:0] dma_ok;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    ep_req_cell #(
      .IS_CTRL (i < NUM_CTRL)
    ) u_cell (
      .clk       (clk),
      .rst       (rst),
      .ep_evt    (ep_evt[i]),
      .frame_evt (frame_evt),
      .irq_en    (ep_irq_en[i]),
      .is_iso    (ep_iso[i]),
      .done      (xfer_done[i]),
      .flag      (flags[i])
    );
  end

  assign dma_ok = dma_en & ~CTRL_MASK;

  ep_start_gen #(
    .N (NUM_EP)
  ) u_start (
    .clk    (clk),
    .rst    (rst),
    .flag   (flags),
    .dma_ok (dma_ok),
    .pulse  (start_pulse)
  );

  assign req_status = flags;

endmodule

// File: rtl/ep_dma_req_chk.sv
module ep_dma_req_chk #(
  parameter int unsigned NUM_EP   = 32,
  parameter int unsigned NUM_CTRL = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_EP-1:0] ep_evt,
  input logic              frame_evt,
  input logic [NUM_EP-1:0] ep_irq_en,
  input logic [NUM_EP-1:0] ep_iso,
  input logic [NUM_EP-1:0] dma_en,
  input logic [NUM_EP-1:0] xfer_done,
  input logic [NUM_EP-1:0] req_status,
  input logic [NUM_EP-1:0] start_pulse
);

  logic [NUM_EP-1:0] may_set;
  assign may_set = ~ep_irq_en & ((ep_evt & ~ep_iso) | ({NUM_EP{frame_evt}} & ep_iso));

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (req_status == '0 && start_pulse == '0)); // R1
  AST_CTRL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (req_status[NUM_CTRL-1:0] == '0) && (start_pulse[NUM_CTRL-1:0] == '0)); // R6
  AST_RISE_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((req_status & ~$past(req_status) & ~$past(may_set)) == '0)); // R2
  AST_FALL_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~req_status & $past(req_status) & ~$past(xfer_done)) == '0)); // R11
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((start_pulse & $past(start_pulse)) == '0)); // R9
  AST_PULSE_ARMED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((start_pulse & ~$past(req_status & dma_en)) == '0)); // R10

endmodule

bind ep_dma_req ep_dma_req_chk #(.NUM_EP(NUM_EP), .NUM_CTRL(NUM_CTRL)) u_chk (
  .clk(clk), .rst(rst), .ep_evt(ep_evt), .frame_evt(frame_evt),
  .ep_irq_en(ep_irq_en), .ep_iso(ep_iso), .dma_en(dma_en),
  .xfer_done(xfer_done), .req_status(req_status), .start_pulse(start_pulse)
);

// File: tb/ep_dma_req_bench.sv
`timescale 1ns/1ps
module ep_dma_req_bench;

  localparam int unsigned NUM_EP = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_EP-1:0] ep_evt = '0;
  logic              frame_evt = 1'b0;
  logic [NUM_EP-1:0] ep_irq_en = '0;
  logic [NUM_EP-1:0] ep_iso = '0;
  logic [NUM_EP-1:0] dma_en = '0;
  logic [NUM_EP-1:0] xfer_done = '0;
  logic [NUM_EP-1:0] req_status;
  logic [NUM_EP-1:0] start_pulse;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ep_dma_req u_ep_dma_req (
    .clk(clk), .rst(rst), .ep_evt(ep_evt), .frame_evt(frame_evt),
    .ep_irq_en(ep_irq_en), .ep_iso(ep_iso), .dma_en(dma_en),
    .xfer_done(xfer_done), .req_status(req_status), .start_pulse(start_pulse)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [NUM_EP-1:0] act, input logic [NUM_EP-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    ep_evt = '0; frame_evt = 1'b0; ep_irq_en = '0; ep_iso = '0; dma_en = '0;
    xfer_done = '1;
    tick();
    xfer_done = '0;
    tick();
  endtask

  task automatic t_reset();
    check("R1 status in reset", req_status, '0);
    check("R1 strobe in reset", start_pulse, '0);
    rst = 1'b0;
    tick();
    check("R1 status after reset", req_status, '0);
    check("R1 strobe after reset", start_pulse, '0);
  endtask

  task automatic t_event_path();
    ep_irq_en = 32'h40;
    ep_evt = 32'h60;
    tick();
    ep_evt = '0;
    check("R2 R3 event set masked", req_status, 32'h20);
    tick();
    check("R10 no strobe without dma", start_pulse, '0);
    dma_en = 32'h20;
    tick();
    check("R10 strobe on late dma enable", start_pulse, 32'h20);
    tick();
    check("R9 strobe lasts one cycle", start_pulse, '0);
    tick();
    check("R11 flag held", req_status, 32'h20);
    xfer_done = 32'h20;
    tick();
    xfer_done = '0;
    check("R7 done clears", req_status, '0);
    clear_all();
  endtask

  task automatic t_iso_path();
    ep_iso = 32'h8000_0300;
    ep_irq_en = 32'h200;
    ep_evt = 32'h8000_0100;
    tick();
    ep_evt = '0;
    check("R4 iso ignores own event", req_status, '0);
    frame_evt = 1'b1;
    tick();
    frame_evt = 1'b0;
    check("R4 R5 frame sets iso only", req_status, 32'h8000_0100);
    clear_all();
  endtask

  task automatic t_ctrl();
    dma_en = '1;
    ep_evt = 32'h3;
    tick();
    ep_evt = '0;
    check("R6 ctrl ignores event", req_status, '0);
    ep_iso = 32'h3;
    frame_evt = 1'b1;
    tick();
    frame_evt = 1'b0;
    check("R6 ctrl ignores frame", req_status, '0);
    tick();
    check("R6 ctrl never strobes", start_pulse, '0);
    clear_all();
  endtask

  task automatic t_set_wins();
    ep_evt = 32'h1000;
    tick();
    ep_evt = 32'h1000;
    xfer_done = 32'h1000;
    tick();
    ep_evt = '0; xfer_done = '0;
    check("R8 set beats clear", req_status, 32'h1000);
    xfer_done = 32'h1000;
    tick();
    xfer_done = '0;
    check("R7 clear after collision", req_status, '0);
    clear_all();
  endtask

  task automatic t_restrobe();
    dma_en = 32'h10_0000;
    ep_evt = 32'h10_0000;
    tick();
    ep_evt = '0;
    tick();
    check("R9 first strobe", start_pulse, 32'h10_0000);
    ep_evt = 32'h10_0000;
    tick();
    ep_evt = '0;
    check("R9 no strobe while held", start_pulse, '0);
    dma_en = '0;
    tick();
    dma_en = 32'h10_0000;
    tick();
    check("R9 strobe after re-arm", start_pulse, 32'h10_0000);
    clear_all();
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick();
    tick();
    t_reset();
    t_event_path();
    t_iso_path();
    t_ctrl();
    t_set_wins();
    t_restrobe();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule